// File: doc/BRIEF.md
# In-Order Response Dispatch Queue

This block sits between the request-side and response-side controllers of a bridge that joins two non-blocking protocols. On both of them the responder answers in the order the requests were issued. When a request transaction completes and its controller returns to idle, the request side pulses `req_done` with a small operation code, such as read, write or acknowledged write. The queue stores that code. No data is stored.

The response side has one handler per operation code. Each handler asserts its own start condition on `rsp_start`. The queue passes that start through on `rsp_grant` only when the oldest stored code names that handler. This stops responses from being claimed by the wrong handler. When the granted response finishes, the response side pulses `rsp_done` and the oldest entry is removed.

The `full` flag doubles as a stall for the request side: no new request may be issued while it is high. The `empty` flag and `head_valid` show that no response is expected.

Top module: `inorder_dispatch_fifo`

## Requirements
- R1: After a synchronous reset, `empty`=1, `full`=0, `head_valid`=0, and every `rsp_grant` bit is 0.
- R2: Each accepted `req_done` appends `req_op` to the tail. The codes appear on `head_op` in exactly the order they were pushed, one code per accepted `rsp_done`.
- R3: `head_valid` equals NOT `empty`. A code pushed into an empty queue shows on `head_op` with `head_valid`=1 in the cycle after the push edge.
- R4: `rsp_grant[k]` is 1 exactly when `rsp_start[k]`=1, `head_valid`=1 and `head_op`=k. Here k is the plain binary value of the operation code. At most one grant bit is ever high.
- R5: A `rsp_done` while `empty`=1 is ignored: the queue stays empty and a later push is the next head.
- R6: `full` rises once DEPTH entries are held. A `req_done` while `full`=1 is dropped, and the stored codes and their order are unchanged.
- R7: When neither flag is set, a `req_done` and a `rsp_done` in the same cycle are both performed and occupancy does not change. When `full`=1, the same pair removes the head and drops the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_done | input | 1 | Request transaction finished; push `req_op` |
| req_op | input | ID_W | Operation code of the finished request |
| rsp_done | input | 1 | Granted response finished; pop the head |
| rsp_start | input | 2**ID_W | Per-handler protocol start condition |
| rsp_grant | output | 2**ID_W | Per-handler permission to start |
| head_op | output | ID_W | Operation code of the oldest entry |
| head_valid | output | 1 | Queue holds at least one entry |
| full | output | 1 | Queue holds DEPTH entries; stall requests |
| empty | output | 1 | Queue holds no entries |

## Verification
- **Ordering:** mixed sequences of read, write and acknowledged-write codes are drained. This shows whether the queue keeps first-in-first-out order and does not reorder or duplicate codes.
- **Grant gating:** every handler asserts its start at once against differing heads. This separates correct gating by the head code from a grant that only tests occupancy.
- **Boundaries:** pushes against a full queue and pops against an empty one are driven, followed by a drain. These show that dropped operations leave the contents untouched.
- **Simultaneous push and pop:** these are driven at mid occupancy and at full. They separate an unchanged count from a drift by one entry.

// File: rtl/dispf_pkg.sv
package dispf_pkg;
  localparam int OPID_W = 2;

  typedef enum logic [OPID_W-1:0] {
    OP_READ    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_ACKWR   = 2'd2,
    OP_SPARE   = 2'd3
  } op_code_e;
endpackage

// File: rtl/dispf_store.sv
module dispf_store #(
  parameter int W     = 2,
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dispf_ptrs.sv
module dispf_ptrs #(
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic          wr_en,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          full,
  output logic          empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign wr_en   = do_push;

  always_comb begin
    case ({do_push, do_pop})
      2'b10:   cnt_n = cnt_q + CW'(1);
      2'b01:   cnt_n = cnt_q - CW'(1);
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      wptr  <= '0;
      rptr  <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      full  <= (cnt_n == CW'(DEPTH));
      empty <= (cnt_n == '0);
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
    end
  end
endmodule

// File: rtl/dispf_gate.sv
module dispf_gate #(
  parameter int ID_W = 2,
  parameter int NH   = 4
) (
  input  logic [NH-1:0]   start,
  input  logic            valid,
  input  logic [ID_W-1:0] head,
  output logic [NH-1:0]   grant
);
  for (genvar k = 0; k < NH; k++) begin : g_hnd
    localparam logic [ID_W-1:0] KID = ID_W'(k);
    assign grant[k] = start[k] && valid && (head == KID);
  end
endmodule

// File: rtl/inorder_dispatch_fifo.sv
module inorder_dispatch_fifo #(
  parameter int ID_W  = dispf_pkg::OPID_W,
  parameter int DEPTH = 4,
  parameter int NH    = 2 ** ID_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_done,
  input  logic [ID_W-1:0] req_op,
  input  logic            rsp_done,
  input  logic [NH-1:0]   rsp_start,
  output logic [NH-1:0]   rsp_grant,
  output logic [ID_W-1:0] head_op,
  output logic            head_valid,
  output logic            full,
  output logic            empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          wr_en;
  logic [AW-1:0] wptr, rptr;

  dispf_ptrs #(.DEPTH(DEPTH), .AW(AW)) u_ptrs (
    .clk(clk), .rst(rst), .push(req_done), .pop(rsp_done),
    .wr_en(wr_en), .wptr(wptr), .rptr(rptr), .full(full), .empty(empty)
  );

  dispf_store #(.W(ID_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(wr_en), .waddr(wptr), .wdata(req_op),
    .raddr(rptr), .rdata(head_op)
  );

  assign head_valid = !empty;

  dispf_gate #(.ID_W(ID_W), .NH(NH)) u_gate (
    .start(rsp_start), .valid(head_valid), .head(head_op), .grant(rsp_grant)
  );
endmodule

// File: rtl/dispf_chk.sv
module dispf_chk #(
  parameter int ID_W = 2,
  parameter int NH   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_done,
  input logic [ID_W-1:0] req_op,
  input logic            rsp_done,
  input logic [NH-1:0]   rsp_start,
  input logic [NH-1:0]   rsp_grant,
  input logic [ID_W-1:0] head_op,
  input logic            head_valid,
  input logic            full,
  input logic            empty
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> empty && !full && !head_valid);

  a_r2_push_to_head: assert property (@(posedge clk) disable iff (rst)
    empty && req_done |=> !empty && head_op == $past(req_op));

  a_r3_valid_vs_empty: assert property (@(posedge clk) disable iff (rst)
    head_valid != empty);

  a_r4_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_grant));

  a_r4_grant_needs_start: assert property (@(posedge clk) disable iff (rst)
    (rsp_grant & ~rsp_start) == '0);

  a_r4_grant_matches_head: assert property (@(posedge clk) disable iff (rst)
    |rsp_grant |-> head_valid && rsp_grant[head_op]);

  a_r5_pop_empty_noop: assert property (@(posedge clk) disable iff (rst)
    empty && rsp_done && !req_done |=> empty);

  a_r6_push_full_dropped: assert property (@(posedge clk) disable iff (rst)
    full && req_done && !rsp_done |=> full && $stable(head_op));

  a_r7_both_keep_level: assert property (@(posedge clk) disable iff (rst)
    !full && !empty && req_done && rsp_done |=> !full && !empty);

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

bind inorder_dispatch_fifo dispf_chk #(.ID_W(ID_W), .NH(NH)) u_chk (.*);

// File: tb/inorder_dispatch_fifo_tb.sv
`timescale 1ns/1ps
module inorder_dispatch_fifo_tb;
  import dispf_pkg::*;

  localparam int ID_W  = OPID_W;
  localparam int DEPTH = 4;
  localparam int NH    = 2 ** ID_W;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_done = 1'b0;
  logic [ID_W-1:0] req_op = '0;
  logic            rsp_done = 1'b0;
  logic [NH-1:0]   rsp_start = '0;
  logic [NH-1:0]   rsp_grant;
  logic [ID_W-1:0] head_op;
  logic            head_valid, full, empty;

  int n_chk = 0, n_fail = 0, cyc = 0, cnt = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  inorder_dispatch_fifo #(.ID_W(ID_W), .DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Driver: one cycle of stimulus; scoreboard checks before the edge,
  // model update on the edge.
  task automatic step(input string tag, input bit push, input int op,
                      input bit pop, input logic [NH-1:0] st);
    @(negedge clk);
    chk(full == (cnt == DEPTH), tag, int'(full), int'(cnt == DEPTH));
    chk(empty == (cnt == 0), tag, int'(empty), int'(cnt == 0));
    chk(head_valid == (cnt > 0), {tag, " R3"}, int'(head_valid), int'(cnt > 0));
    req_done = push; req_op = ID_W'(op); rsp_done = pop; rsp_start = st;
    #1;
    for (int k = 0; k < NH; k++) begin
      bit e = st[k] && cnt > 0 && exp_q[0] == k;
      chk(rsp_grant[k] == e, {tag, " R4"}, int'(rsp_grant[k]), int'(e));
    end
    if (pop && cnt > 0)
      chk(int'(head_op) == exp_q[0], {tag, " R2"}, int'(head_op), exp_q[0]);
    @(posedge clk);
    begin
      bit ap = push && cnt < DEPTH;
      bit ao = pop && cnt > 0;
      if (ao) begin void'(exp_q.pop_front()); cnt--; end
      if (ap) begin exp_q.push_back(op); cnt++; end
    end
  endtask

  task automatic drain(input string tag);
    while (cnt > 0) step(tag, 1'b0, 0, 1'b1, '0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected <= 20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state, all starts asserted yet nothing granted
    step("R1", 1'b0, 0, 1'b0, '1);
    // R2/R3: ordered codes, drained in order
    step("R3", 1'b1, OP_ACKWR, 1'b0, '0);
    step("R3", 1'b0, 0, 1'b0, '1);
    step("R2", 1'b1, OP_READ, 1'b0, '0);
    step("R2", 1'b1, OP_WRITE, 1'b0, '0);
    drain("R2");
    // R5: pop on empty ignored, next push becomes head
    step("R5", 1'b0, 0, 1'b1, '0);
    step("R5", 1'b0, 0, 1'b1, '1);
    step("R5", 1'b1, OP_WRITE, 1'b0, '0);
    step("R5", 1'b0, 0, 1'b0, 4'b0010);
    drain("R5");
    // R6: fill, overflow dropped, order preserved
    step("R6", 1'b1, OP_READ, 1'b0, '0);
    step("R6", 1'b1, OP_ACKWR, 1'b0, '0);
    step("R6", 1'b1, OP_SPARE, 1'b0, '0);
    step("R6", 1'b1, OP_WRITE, 1'b0, '0);
    step("R6", 1'b1, OP_READ, 1'b0, '1);
    step("R6", 1'b1, OP_SPARE, 1'b0, '0);
    // R7: push+pop at full drops push, removes head
    step("R7", 1'b1, OP_READ, 1'b1, '0);
    // R7: push+pop at mid level keeps count
    step("R7", 1'b1, OP_WRITE, 1'b1, '1);
    step("R7", 1'b1, OP_ACKWR, 1'b1, 4'b0101);
    // R4: each handler alone against the head
    for (int k = 0; k < NH; k++) step("R4", 1'b0, 0, 1'b0, NH'(1) << k);
    drain("R7");
    // R4: rotate heads and request all handlers
    for (int k = 0; k < NH; k++) step("R4", 1'b1, k, 1'b0, '0);
    for (int k = 0; k < NH; k++) step("R4", 1'b0, 0, 1'b1, '1);
    step("R1", 1'b0, 0, 1'b0, '0);
    // R1: reset mid-occupancy
    step("R1", 1'b1, OP_WRITE, 1'b0, '0);
    @(negedge clk); rst = 1'b1; req_done = 1'b0; rsp_done = 1'b0; rsp_start = '0;
    @(posedge clk); exp_q.delete(); cnt = 0;
    @(negedge clk); rst = 1'b0;
    step("R1", 1'b0, 0, 1'b0, '1);
    step("R1", 1'b0, 0, 1'b0, '0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule